// File: doc/BRIEF.md
# Week-Based Real-Time Counter

This block keeps elapsed time as seconds, minutes, hours, day of the week and a count of whole weeks. A prescaler turns a slow reference into a one-second step. The reference is either a synchronised subclock strobe (`sub_tick`, one pulse per subclock period, 32768 pulses per second by default) or the main clock itself, chosen by `src_main`. Each step ripples through the field counters as a carry chain. The week counter is 12 bits wide and flags a wrap with a sticky bit.

While `cnt_en` is low, software can preset any field or the interval compare value through a plain write strobe. The block also has an interval-timer mode. In that mode the time fields hold, and a 16-bit counter driven by the main clock raises the same interrupt pulse each time it matches the compare value. All field outputs are registers that change on one clock edge, so a sample taken in any cycle is a coherent time value. The write port has no flow control: a write is a single-cycle strobe and is never back-pressured.

Top module: `rtc_week_counter`

## Requirements
- R1: After reset all time fields, `week_ovf` and `tick_irq` are 0, and the compare value is CMP_RST (999 by default).
- R2: In watch mode with `cnt_en`=1, seconds advance once per SUB_DIV `sub_tick` pulses when `src_main`=0, and once per MAIN_DIV clock cycles when `src_main`=1.
- R3: While disabled, the prescaler is held at zero, so after `cnt_en` rises the first second step comes only after a full period. A brief disable therefore restarts the period.
- R4: Seconds and minutes wrap 59→0, hours wrap 23→0 and days wrap 6→0. Each wrap carries one into the next field on the same edge.
- R5: The week counter wraps 4095→0 and sets `week_ovf`. The flag stays set until `ovf_clr` is high on an edge with no new wrap; a wrap and a clear on the same edge leave it set.
- R6: With `cnt_en`=0, a `wr_en` strobe loads `wr_data` on the next edge into the target chosen by `wr_sel`: 0 seconds, 1 minutes, 2 hours, 3 days, 4 weeks, 5 interval compare. Codes 6 and 7 change nothing.
- R7: A write is ignored while `cnt_en`=1, and a write whose value exceeds the field's maximum (59, 59, 23, 6, 4095) is ignored.
- R8: `tick_irq` is a one-cycle pulse. In watch mode it rises on the same edge that shows the advanced seconds value.
- R9: With `mode_interval`=1 and `cnt_en`=1, `tick_irq` pulses every compare+1 main-clock cycles, the first pulse compare+1 cycles after enabling. The time fields hold and `sub_tick` has no effect.
- R10: All field outputs update on the same clock edge, so no partially carried value is ever visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sub_tick | input | 1 | One-cycle strobe per subclock period |
| src_main | input | 1 | 1 selects the main clock as the one-second reference |
| cnt_en | input | 1 | Counting enable |
| mode_interval | input | 1 | 1 selects interval-timer mode |
| wr_en | input | 1 | Write strobe for field or compare load |
| wr_sel | input | 3 | Write target code |
| wr_data | input | 16 | Write value |
| ovf_clr | input | 1 | Clears the week wrap flag |
| sec_o | output | 6 | Seconds |
| min_o | output | 6 | Minutes |
| hour_o | output | 5 | Hours |
| day_o | output | 3 | Day of week |
| week_o | output | 12 | Elapsed weeks |
| week_ovf | output | 1 | Sticky week wrap flag |
| tick_irq | output | 1 | Second or interval interrupt pulse |

## Verification
Each output has a fixed due cycle:
- A write appears on the edge right after its strobe.
- A second step, with its whole carry chain and the interrupt pulse, appears on the edge that completes the SUB_DIV-th counted subclock pulse or the MAIN_DIV-th main-clock cycle after enabling.
- An interval pulse appears compare+1 edges after enabling, or after the previous pulse.

The bench holds a behavioural model that steps on the same rising edge from the same inputs. It compares every output on the following falling edge. Directed checks count the falling edges or counted strobes from an event up to the pulse, and compare that count with these latencies.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic [2:0] {
    SEL_SEC  = 3'd0,
    SEL_MIN  = 3'd1,
    SEL_HOUR = 3'd2,
    SEL_DAY  = 3'd3,
    SEL_WEEK = 3'd4,
    SEL_CMP  = 3'd5
  } fsel_e;

  localparam int SEC_W  = 6;
  localparam int MIN_W  = 6;
  localparam int HOUR_W = 5;
  localparam int DAY_W  = 3;
  localparam int WEEK_W = 12;
  localparam int SEC_MAX  = 59;
  localparam int MIN_MAX  = 59;
  localparam int HOUR_MAX = 23;
  localparam int DAY_MAX  = 6;
  localparam int WEEK_MAX = (1 << WEEK_W) - 1;
  localparam int DATA_W = 16;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int SUB_DIV  = 32768,
  parameter int MAIN_DIV = 20000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic src_main,
  input  logic sub_tick,
  output logic tick
);
  localparam int MAXD = (SUB_DIV > MAIN_DIV) ? SUB_DIV : MAIN_DIV;
  localparam int PW   = $clog2(MAXD) + 1;

  logic [PW-1:0] pc;
  logic [PW-1:0] limit;
  logic          step;
  logic          at_end;

  assign limit  = src_main ? PW'(MAIN_DIV - 1) : PW'(SUB_DIV - 1);
  assign step   = src_main | sub_tick;
  assign at_end = (pc >= limit);
  assign tick   = run & step & at_end;

  always_ff @(posedge clk) begin
    if (!rst_n)     pc <= '0;
    else if (!run)  pc <= '0;
    else if (step)  pc <= at_end ? '0 : pc + 1'b1;
  end

  // R3: an idle prescaler restarts from zero
  a_r3_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pc == '0));
  // R2: phase never exceeds the longest period
  a_r2_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pc <= PW'(MAXD - 1));
endmodule

// File: rtl/rtc_field.sv
module rtc_field #(
  parameter int W   = 6,
  parameter int MAX = 59,
  parameter int LDW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           inc,
  input  logic           ld,
  input  logic [LDW-1:0] ld_val,
  output logic [W-1:0]   val,
  output logic           carry
);
  localparam logic [W-1:0]   MAXV  = W'(MAX);
  localparam logic [LDW-1:0] MAXLD = LDW'(MAX);

  logic ld_ok;
  assign ld_ok = ld & (ld_val <= MAXLD);
  assign carry = inc & (val == MAXV);

  always_ff @(posedge clk) begin
    if (!rst_n)     val <= '0;
    else if (ld_ok) val <= ld_val[W-1:0];
    else if (inc)   val <= carry ? '0 : val + 1'b1;
  end

  // R4: stepping from the top value returns to zero
  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld && val == MAXV) |=> (val == '0));
  // R7: an out-of-range load leaves the field alone
  a_r7_bad_load: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !inc && ld_val > MAXLD) |=> $stable(val));
  // R4: never beyond the field's top value
  a_r4_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    val <= MAXV);
endmodule

// File: rtl/rtc_interval.sv
module rtc_interval #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] cmp,
  output logic          expire
);
  logic [CW-1:0] ic;

  assign expire = run & (ic == cmp);

  always_ff @(posedge clk) begin
    if (!rst_n)    ic <= '0;
    else if (!run) ic <= '0;
    else           ic <= expire ? '0 : ic + 1'b1;
  end

  // R9: the running count stays within the programmed period
  a_r9_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (ic <= cmp));
  // R9: a match reloads to zero
  a_r9_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && run) |=> (ic == '0));
endmodule

// File: rtl/rtc_week_counter.sv
module rtc_week_counter
  import rtc_pkg::*;
#(
  parameter int SUB_DIV  = 32768,
  parameter int MAIN_DIV = 20000000,
  parameter int CMP_RST  = 999
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sub_tick,
  input  logic              src_main,
  input  logic              cnt_en,
  input  logic              mode_interval,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ovf_clr,
  output logic [SEC_W-1:0]  sec_o,
  output logic [MIN_W-1:0]  min_o,
  output logic [HOUR_W-1:0] hour_o,
  output logic [DAY_W-1:0]  day_o,
  output logic [WEEK_W-1:0] week_o,
  output logic              week_ovf,
  output logic              tick_irq
);
  fsel_e             sel;
  logic              wr_ok;
  logic              watch_run;
  logic              intv_run;
  logic              sec_step;
  logic              intv_exp;
  logic              c_sec, c_min, c_hour, c_day, c_week;
  logic [DATA_W-1:0] cmp_q;

  assign sel       = fsel_e'(wr_sel);
  assign wr_ok     = wr_en & ~cnt_en;
  assign watch_run = cnt_en & ~mode_interval;
  assign intv_run  = cnt_en & mode_interval;

  rtc_prescaler #(.SUB_DIV(SUB_DIV), .MAIN_DIV(MAIN_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(watch_run), .src_main(src_main),
    .sub_tick(sub_tick), .tick(sec_step)
  );

  rtc_field #(.W(SEC_W), .MAX(SEC_MAX), .LDW(DATA_W)) u_sec (
    .clk(clk), .rst_n(rst_n), .inc(sec_step), .ld(wr_ok && sel == SEL_SEC),
    .ld_val(wr_data), .val(sec_o), .carry(c_sec)
  );
  rtc_field #(.W(MIN_W), .MAX(MIN_MAX), .LDW(DATA_W)) u_min (
    .clk(clk), .rst_n(rst_n), .inc(c_sec), .ld(wr_ok && sel == SEL_MIN),
    .ld_val(wr_data), .val(min_o), .carry(c_min)
  );
  rtc_field #(.W(HOUR_W), .MAX(HOUR_MAX), .LDW(DATA_W)) u_hour (
    .clk(clk), .rst_n(rst_n), .inc(c_min), .ld(wr_ok && sel == SEL_HOUR),
    .ld_val(wr_data), .val(hour_o), .carry(c_hour)
  );
  rtc_field #(.W(DAY_W), .MAX(DAY_MAX), .LDW(DATA_W)) u_day (
    .clk(clk), .rst_n(rst_n), .inc(c_hour), .ld(wr_ok && sel == SEL_DAY),
    .ld_val(wr_data), .val(day_o), .carry(c_day)
  );
  rtc_field #(.W(WEEK_W), .MAX(WEEK_MAX), .LDW(DATA_W)) u_week (
    .clk(clk), .rst_n(rst_n), .inc(c_day), .ld(wr_ok && sel == SEL_WEEK),
    .ld_val(wr_data), .val(week_o), .carry(c_week)
  );

  rtc_interval #(.CW(DATA_W)) u_intv (
    .clk(clk), .rst_n(rst_n), .run(intv_run), .cmp(cmp_q), .expire(intv_exp)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q    <= DATA_W'(CMP_RST);
      week_ovf <= 1'b0;
      tick_irq <= 1'b0;
    end else begin
      if (wr_ok && sel == SEL_CMP) cmp_q <= wr_data;
      if (c_week)       week_ovf <= 1'b1;
      else if (ovf_clr) week_ovf <= 1'b0;
      tick_irq <= sec_step | intv_exp;
    end
  end

  // R7: a disabled counter without writes keeps every field
  a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !wr_en) |=> $stable({week_o, day_o, hour_o, min_o, sec_o}));
  // R5: the wrap flag persists until cleared
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (week_ovf && !ovf_clr) |=> week_ovf);
  // R9: interval mode freezes the time fields
  a_r9_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && mode_interval) |=> $stable({week_o, day_o, hour_o, min_o, sec_o}));
  // R8: a watch-mode pulse accompanies a changed seconds value
  a_r8_pulse_with_step: assert property (@(posedge clk) disable iff (!rst_n)
    (watch_run && $past(watch_run) && tick_irq) |-> !$stable(sec_o));
endmodule

// File: tb/rtc_week_counter_tb.sv
module rtc_week_counter_tb;
  localparam int SUBD = 4;
  localparam int MAIND = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sub_tick = 1'b0, src_main = 1'b0, cnt_en = 1'b0, mode_interval = 1'b0;
  logic wr_en = 1'b0, ovf_clr = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [5:0] sec_o, min_o;
  logic [4:0] hour_o;
  logic [2:0] day_o;
  logic [11:0] week_o;
  logic week_ovf, tick_irq;

  int checks = 0, errors = 0;
  bit done = 0;
  bit sub_on = 0;
  int sub_phase = 0;
  int sub_seen = 0;

  // reference model state
  int m_s = 0, m_m = 0, m_h = 0, m_d = 0, m_w = 0, m_cmp = 999;
  int m_pc = 0, m_ic = 0;
  bit m_ovf = 0, m_irq = 0;

  always #4 clk = ~clk;

  rtc_week_counter #(.SUB_DIV(SUBD), .MAIN_DIV(MAIND), .CMP_RST(999)) u_dut (
    .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick), .src_main(src_main),
    .cnt_en(cnt_en), .mode_interval(mode_interval), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .ovf_clr(ovf_clr),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .day_o(day_o),
    .week_o(week_o), .week_ovf(week_ovf), .tick_irq(tick_irq)
  );

  always @(posedge clk) begin
    bit wrapped;
    int lim;
    wrapped = 0;
    if (!rst_n) begin
      m_s = 0; m_m = 0; m_h = 0; m_d = 0; m_w = 0; m_cmp = 999;
      m_pc = 0; m_ic = 0; m_ovf = 0; m_irq = 0;
    end else begin
      m_irq = 0;
      if (!cnt_en) begin
        m_pc = 0; m_ic = 0;
        if (wr_en) begin
          case (wr_sel)
            3'd0: if (wr_data < 60) m_s = wr_data;
            3'd1: if (wr_data < 60) m_m = wr_data;
            3'd2: if (wr_data < 24) m_h = wr_data;
            3'd3: if (wr_data < 7) m_d = wr_data;
            3'd4: if (wr_data < 4096) m_w = wr_data;
            3'd5: m_cmp = wr_data;
            default: ;
          endcase
        end
      end else if (mode_interval) begin
        m_pc = 0;
        if (m_ic == m_cmp) begin m_ic = 0; m_irq = 1; end
        else m_ic++;
      end else begin
        m_ic = 0;
        lim = src_main ? MAIND : SUBD;
        if (src_main || sub_tick) begin
          if (m_pc >= lim - 1) begin
            m_pc = 0; m_irq = 1;
            m_s++;
            if (m_s == 60) begin
              m_s = 0; m_m++;
              if (m_m == 60) begin
                m_m = 0; m_h++;
                if (m_h == 24) begin
                  m_h = 0; m_d++;
                  if (m_d == 7) begin
                    m_d = 0; m_w++;
                    if (m_w == 4096) begin m_w = 0; wrapped = 1; end
                  end
                end
              end
            end
          end else m_pc++;
        end
      end
      if (wrapped) m_ovf = 1;
      else if (ovf_clr) m_ovf = 0;
    end
  end

  always @(posedge clk)
    if (sub_tick && cnt_en && !mode_interval) sub_seen++;

  always @(negedge clk) begin
    if (sub_on) begin
      sub_phase++;
      sub_tick = (sub_phase % 3 == 0);
    end else sub_tick = 0;
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // R10: every output matches the model on every cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R10", "coherent time",
            {week_o, day_o, hour_o, min_o, sec_o},
            {m_w[11:0], m_d[2:0], m_h[4:0], m_m[5:0], m_s[5:0]});
      check("R8", "irq vs model", tick_irq, m_irq);
      check("R5", "ovf vs model", week_ovf, m_ovf);
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic wr(input int sel, input int data);
    wr_en = 1; wr_sel = sel[2:0]; wr_data = data[15:0];
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick_irq && n < 5000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    int held;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", "fields after reset", {week_o, day_o, hour_o, min_o, sec_o}, 0);
    check("R1", "ovf after reset", week_ovf, 0);
    check("R1", "irq after reset", tick_irq, 0);

    // default compare gives a 1000-cycle interval
    mode_interval = 1; cnt_en = 1;
    wait_irq(n);
    check("R1", "default interval", n, 1000);
    cnt_en = 0; mode_interval = 0;
    @(negedge clk);

    // loads while disabled
    wr(0, 58); wr(1, 59); wr(2, 23); wr(3, 6); wr(4, 4095);
    check("R6", "sec load", sec_o, 58);
    check("R6", "min load", min_o, 59);
    check("R6", "hour load", hour_o, 23);
    check("R6", "day load", day_o, 6);
    check("R6", "week load", week_o, 4095);
    wr(6, 5);
    check("R6", "unused code", {week_o, day_o, hour_o, min_o, sec_o},
          {12'd4095, 3'd6, 5'd23, 6'd59, 6'd58});
    wr(0, 60);
    check("R7", "out-of-range sec", sec_o, 58);
    wr(2, 24);
    check("R7", "out-of-range hour", hour_o, 23);

    // watch mode from the subclock
    sub_on = 1; src_main = 0;
    sub_seen = 0; cnt_en = 1;
    wait_irq(n);
    check("R3", "sub pulses to first step", sub_seen, SUBD);
    check("R8", "irq with new second", sec_o, 59);
    wait_irq(n);
    check("R4", "full rollover", {week_o, day_o, hour_o, min_o, sec_o}, 0);
    check("R5", "week wrap sets flag", week_ovf, 1);
    @(negedge clk);
    check("R8", "irq one cycle", tick_irq, 0);
    wr(0, 30);
    check("R7", "write while enabled", sec_o, 0);
    repeat (5) @(negedge clk);
    check("R5", "flag sticky", week_ovf, 1);
    ovf_clr = 1; @(negedge clk); ovf_clr = 0;
    check("R5", "flag cleared", week_ovf, 0);
    cnt_en = 0; sub_on = 0;
    @(negedge clk);

    // main-clock source, clear held across a wrap
    wr(0, 59); wr(1, 59); wr(2, 23); wr(3, 6); wr(4, 4095);
    src_main = 1; ovf_clr = 1; cnt_en = 1;
    wait_irq(n);
    check("R2", "main-clock period", n, MAIND);
    check("R5", "wrap beats clear", week_ovf, 1);
    check("R4", "week wraps to 0", week_o, 0);
    @(negedge clk);
    check("R5", "clear after wrap", week_ovf, 0);
    ovf_clr = 0;

    // brief disable restarts the period
    repeat (2) @(negedge clk);
    cnt_en = 0; @(negedge clk); cnt_en = 1;
    wait_irq(n);
    check("R3", "restart after disable", n, MAIND);
    cnt_en = 0; src_main = 0;
    @(negedge clk);

    // interval mode with a programmed compare
    wr(5, 4);
    held = sec_o;
    sub_on = 1; mode_interval = 1; cnt_en = 1;
    wait_irq(n);
    check("R9", "first interval", n, 5);
    wait_irq(n);
    check("R9", "second interval", n, 5);
    check("R9", "fields held", sec_o, held);
    cnt_en = 0; mode_interval = 0; sub_on = 0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule